// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer. Its single clock stands in for the RF input ahead of the prescaler. It models a dual-modulus prescaler that divides by 64 or 65, a main counter and a swallow counter. The result is one output pulse every 64·M + S input clocks, and that pulse goes to the phase detector. The modulus-control signal is also an output. It is high while the prescaler must divide by 65. An external prescaler can use it when the internal model is bypassed.

The division values come from a configuration latch. `cfg_load` writes the pair (`main_val`, `swallow_val`) into a shadow register. The counters take the shadow value only at the boundary of an output cycle, so a cycle is never cut short. If `cfg_load` is high on the boundary clock itself, the incoming value is used directly. `cfg_load` is a plain strobe with no back-pressure, because a write never stalls. When `run_en` is low the block is powered down: the counters are held cleared and both outputs stay low. The shadow register can still be written in that state.

The parameter `PSC_MODE` chooses how the clock is read. `PSC_INTERNAL` models the 64/65 prescaler inside the block. `PSC_EXTERNAL` treats every clock as one prescaler output period, so the block produces one pulse per M clocks.

Top module: `swallow_divider`

## Requirements
- R1: While `rst_n` is low, `div_pulse` and `mod_sel` are both 0. After reset the shadow holds M=5, S=0.
- R2: With `run_en` high and a fixed pair S < M, successive `div_pulse` pulses are exactly 64·M + S clocks apart, for M in 5..2047 and S in 0..63.
- R3: `div_pulse` is high for exactly one clock per output cycle.
- R4: `mod_sel` is high (divide by 65) for the first S prescaler periods of each output cycle and low for the remaining M − S. This is 65·S contiguous clocks per cycle in internal mode.
- R5: A pair loaded with `cfg_load` in the middle of a cycle does not change that cycle's length. It takes effect from the next cycle onward.
- R6: While `run_en` is low, `div_pulse` and `mod_sel` are 0 from the next clock on. After `run_en` is raised on clock edge E0, the first `div_pulse` is high in the clock that follows edge E0 + 64·M + S.
- R7: A pair loaded while `run_en` is low is held, and it sets the first cycle after enabling.
- R8: With S = 0, `mod_sel` never goes high and the period is 64·M.
- R9: With `PSC_MODE = PSC_EXTERNAL`, each clock counts as one prescaler period. The pulse spacing is M clocks and `mod_sel` is high for the first S clocks of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (prescaler input, or prescaler output in external mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = running, 0 = powered down (counters held cleared) |
| cfg_load | input | 1 | One-clock strobe that writes `main_val`/`swallow_val` to the shadow register |
| main_val | input | MW (11) | Main counter value M |
| swallow_val | input | SW (6) | Swallow counter value S |
| div_pulse | output | 1 | One-clock pulse at the end of each output cycle |
| mod_sel | output | 1 | Prescaler modulus select: 1 = divide by 65, 0 = divide by 64 |

## Verification
A main or swallow count that goes wrong inside the block shows up at the pins within one output cycle. The spacing between two `div_pulse` pulses moves off 64·M + S, and the number of clocks with `mod_sel` high in that cycle moves off 65·S. A prescaler that counts one too many or too few clocks gives an error of exactly M clocks per cycle, so the very next pulse exposes it. A boundary-load fault shows up in the cycle where the load lands: that cycle gets the new length instead of the old one. An enable fault shows up either as activity while powered down or as a first pulse that is off by a clock after re-enable.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

  typedef enum logic {
    PSC_INTERNAL = 1'b0,
    PSC_EXTERNAL = 1'b1
  } psc_mode_e;

  localparam int unsigned PSC_LOG2_DFLT = 6;
  localparam int unsigned MAIN_RST_VAL  = 5;
  localparam int unsigned SWAL_RST_VAL  = 0;

endpackage

// File: rtl/swallow_div_cfg.sv
module swallow_div_cfg #(
  parameter int unsigned MW    = 11,
  parameter int unsigned SW    = 6,
  parameter int unsigned M_RST = 5,
  parameter int unsigned S_RST = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [MW-1:0] main_val,
  input  logic [SW-1:0] swallow_val,
  output logic [MW-1:0] nxt_main,
  output logic [SW-1:0] nxt_swal
);

  logic [MW-1:0] shd_main;
  logic [SW-1:0] shd_swal;

  // the shadow stays writable in every run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_main <= MW'(M_RST);
      shd_swal <= SW'(S_RST);
    end else if (cfg_load) begin
      shd_main <= main_val;
      shd_swal <= swallow_val;
    end
  end

  // a load that lands on a boundary clock is taken directly
  assign nxt_main = cfg_load ? main_val    : shd_main;
  assign nxt_swal = cfg_load ? swallow_val : shd_swal;

endmodule

// File: rtl/swallow_div_psc.sv
module swallow_div_psc
  import swallow_div_pkg::*;
#(
  parameter psc_mode_e   PSC_MODE = PSC_INTERNAL,
  parameter int unsigned PW       = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic modsel,
  output logic tick
);

  if (PSC_MODE == PSC_EXTERNAL) begin : g_ext
    // every input clock is already one prescaler output period
    assign tick = run;
  end else begin : g_int
    localparam int unsigned PCW = PW + 1;
    localparam logic [PCW-1:0] LIM_LO = PCW'((1 << PW) - 1);
    localparam logic [PCW-1:0] LIM_HI = PCW'(1 << PW);

    logic [PCW-1:0] pc;
    logic [PCW-1:0] lim;

    assign lim  = modsel ? LIM_HI : LIM_LO;
    assign tick = run && (pc == lim);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pc <= '0;
      else if (!run || restart || tick)
        pc <= '0;
      else
        pc <= pc + 1'b1;
    end
  end

endmodule

// File: rtl/swallow_div_cnt.sv
module swallow_div_cnt #(
  parameter int unsigned MW = 11,
  parameter int unsigned SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          reload,
  input  logic          tick,
  input  logic [MW-1:0] nxt_main,
  input  logic [SW-1:0] nxt_swal,
  output logic          running,
  output logic          cyc_end,
  output logic          swallowing
);

  logic [MW-1:0] mrem;
  logic [SW-1:0] srem;

  assign cyc_end    = running && tick && (mrem == MW'(1));
  assign swallowing = running && (srem != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      mrem    <= '0;
      srem    <= '0;
    end else if (!en) begin
      running <= 1'b0;
      mrem    <= '0;
      srem    <= '0;
    end else if (reload) begin
      running <= 1'b1;
      mrem    <= nxt_main;
      srem    <= nxt_swal;
    end else if (tick) begin
      mrem <= mrem - 1'b1;
      if (srem != '0)
        srem <= srem - 1'b1;
    end
  end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_div_pkg::*;
#(
  parameter int unsigned MW       = 11,
  parameter int unsigned SW       = 6,
  parameter int unsigned PW       = PSC_LOG2_DFLT,
  parameter psc_mode_e   PSC_MODE = PSC_INTERNAL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          cfg_load,
  input  logic [MW-1:0] main_val,
  input  logic [SW-1:0] swallow_val,
  output logic          div_pulse,
  output logic          mod_sel
);

  logic [MW-1:0] nxt_main;
  logic [SW-1:0] nxt_swal;
  logic          running;
  logic          cyc_end;
  logic          tick;
  logic          start;
  logic          bnd;

  assign start = run_en && !running;
  assign bnd   = start || cyc_end;

  swallow_div_cfg #(
    .MW(MW), .SW(SW), .M_RST(MAIN_RST_VAL), .S_RST(SWAL_RST_VAL)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .main_val   (main_val),
    .swallow_val(swallow_val),
    .nxt_main   (nxt_main),
    .nxt_swal   (nxt_swal)
  );

  swallow_div_psc #(
    .PSC_MODE(PSC_MODE), .PW(PW)
  ) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (running),
    .restart(cyc_end),
    .modsel (mod_sel),
    .tick   (tick)
  );

  swallow_div_cnt #(
    .MW(MW), .SW(SW)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (run_en),
    .reload    (bnd),
    .tick      (tick),
    .nxt_main  (nxt_main),
    .nxt_swal  (nxt_swal),
    .running   (running),
    .cyc_end   (cyc_end),
    .swallowing(mod_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_pulse <= 1'b0;
    else
      div_pulse <= run_en && cyc_end;
  end

endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic div_pulse,
  input logic mod_sel,
  input logic bnd,
  input logic running
);

  // R3: the output pulse never lasts two clocks
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R6: powered down means both outputs quiet from the next clock
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!div_pulse && !mod_sel));

  // R4: divide-by-65 periods only begin at a cycle boundary
  a_r4_swallow_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_sel) |-> $past(bnd));

  // R2: a pulse follows a boundary taken while already running
  a_r2_pulse_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> ($past(bnd) && $past(running)));

endmodule

bind swallow_divider swallow_divider_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .div_pulse(div_pulse),
  .mod_sel  (mod_sel),
  .bnd      (bnd),
  .running  (running)
);

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;
  import swallow_div_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam int TV_M [NV] = '{5, 5, 6, 7, 10, 33, 64};
  localparam int TV_S [NV] = '{0, 4, 3, 1, 9, 32, 63};
  localparam int TV_N [NV] = '{320, 324, 387, 449, 649, 2144, 4159};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        cfg_load = 1'b0;
  logic [10:0] main_val = '0;
  logic [5:0]  swallow_val = '0;
  logic        div_pulse;
  logic        mod_sel;

  logic        x_en = 1'b0;
  logic        x_load = 1'b0;
  logic [10:0] x_main = '0;
  logic [5:0]  x_swal = '0;
  logic        x_pulse;
  logic        x_mod;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swallow_divider dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_load(cfg_load),
    .main_val(main_val), .swallow_val(swallow_val),
    .div_pulse(div_pulse), .mod_sel(mod_sel)
  );

  swallow_divider #(.PSC_MODE(PSC_EXTERNAL)) dut_ext (
    .clk(clk), .rst_n(rst_n), .run_en(x_en), .cfg_load(x_load),
    .main_val(x_main), .swallow_val(x_swal),
    .div_pulse(x_pulse), .mod_sel(x_mod)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic measure(output int gap, output int hi);
    gap = 0;
    hi = 0;
    do begin
      @(negedge clk);
      gap++;
      if (mod_sel) hi++;
    end while (!div_pulse);
  endtask

  task automatic measure_x(output int gap, output int hi);
    gap = 0;
    hi = 0;
    do begin
      @(negedge clk);
      gap++;
      if (x_mod) hi++;
    end while (!x_pulse);
  endtask

  task automatic load_pair(input int m, input int s);
    @(negedge clk);
    main_val = 11'(m);
    swallow_val = 6'(s);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements): got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gap, hi, k, seen;
    // R1: outputs quiet under reset
    seen = 0;
    repeat (5) begin
      @(negedge clk);
      if (div_pulse || mod_sel || x_pulse || x_mod) seen++;
    end
    chk("R1 outputs during reset", seen, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_en = 1'b1;
    // R1: shadow holds M=5,S=0 after reset -> period 320
    measure(gap, hi);
    measure(gap, hi);
    chk("R1 reset pair period", gap, 320);

    // table walk: R2 period, R4 swallow clocks, R8 via S=0, R3 width
    for (int v = 0; v < NV; v++) begin
      load_pair(TV_M[v], TV_S[v]);
      measure(gap, hi);
      measure(gap, hi);
      chk($sformatf("R2 period M=%0d S=%0d", TV_M[v], TV_S[v]), gap, TV_N[v]);
      chk($sformatf("R4 mod_sel clocks M=%0d S=%0d", TV_M[v], TV_S[v]), hi, 65 * TV_S[v]);
      @(negedge clk);
      chk("R3 pulse width", int'(div_pulse), 0);
    end

    // R8: S=0 never raises mod_sel
    load_pair(9, 0);
    measure(gap, hi);
    measure(gap, hi);
    chk("R8 period with S=0", gap, 576);
    chk("R8 mod_sel stays low", hi, 0);

    // R5: a mid-cycle load leaves the running cycle intact
    load_pair(10, 2);
    measure(gap, hi);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 100) begin
        main_val = 11'd5;
        swallow_val = 6'd1;
        cfg_load = 1'b1;
      end else begin
        cfg_load = 1'b0;
      end
    end while (!div_pulse);
    chk("R5 running cycle keeps old length", k, 642);
    measure(gap, hi);
    chk("R5 next cycle uses new pair", gap, 321);

    // R6: powered down -> outputs quiet
    @(negedge clk);
    run_en = 1'b0;
    seen = 0;
    repeat (400) begin
      @(negedge clk);
      if (div_pulse || mod_sel) seen++;
    end
    chk("R6 quiet while disabled", seen, 0);
    // R7: load while disabled, used at enable
    load_pair(6, 0);
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (div_pulse || mod_sel) seen++;
    end
    chk("R7 load while off stays quiet", seen, 0);
    @(negedge clk);
    run_en = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!div_pulse && k < 2000);
    chk("R6 R7 first pulse after enable", k, 385);

    // R9: external prescaler mode, M=9 S=4
    @(negedge clk);
    x_main = 11'd9;
    x_swal = 6'd4;
    x_load = 1'b1;
    @(negedge clk);
    x_load = 1'b0;
    x_en = 1'b1;
    measure_x(gap, hi);
    measure_x(gap, hi);
    chk("R9 external period", gap, 9);
    chk("R9 external mod_sel clocks", hi, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule